// File: doc/BRIEF.md
# Segmented Linear Address Generator

This block turns a selector and an offset into an address the way a segmented 32-bit processor does it. In protected mode the selector chooses one entry of a small descriptor table. Each entry holds a segment base, a segment limit and an access-rights byte. The block adds the offset to the base, checks the offset against the limit and checks the present bit. If paging is off, the resulting linear address goes straight out as the physical address. If paging is on, the block asks for a page translation and does no translation itself. In real-address mode the block ignores the table and forms a 20-bit address from the selector shifted by four plus the offset.

The table is loaded through a synchronous write port. Lookup and checks are combinational, and a single output register stage presents the result one clock after a request.

Top module: `seg_xlate`

## Requirements
- R1: While reset is asserted and after it is released, `addr_o`, `vld_o`, `flt_o` and `pgreq_o` are all zero. Every table entry reads as not present, so any protected-mode request raises `flt_o` until that entry is written.
- R2: With `pe_i`=0, a request yields `addr_o` = ({`sel_i`,4'h0} + `off_i`[15:0]) mod 2^20, with bits 31:20 zero, `vld_o`=1 and `flt_o`=0. `pg_i` is ignored in this mode.
- R3: With `pe_i`=1, the table entry is chosen by `sel_i`[5:3] only; the other selector bits have no effect. `addr_o` = (base + `off_i`) mod 2^32 and `vld_o`=1.
- R4: With `pe_i`=1, `off_i` greater than the entry's 20-bit limit gives `flt_o`=1, `vld_o`=0 and `addr_o`=0. An offset equal to the limit is accepted.
- R5: With `pe_i`=1, an entry whose rights bit 7 (present) is clear gives `flt_o`=1, `vld_o`=0 and `addr_o`=0.
- R6: With `pe_i`=1 and `pg_i`=1 and no fault, `pgreq_o`=1, `vld_o`=0 and `addr_o` carries the linear address. A fault takes priority over the paging request.
- R7: A request sampled at a rising edge sets the outputs at that same edge. A cycle without a request clears `vld_o`, `flt_o` and `pgreq_o` and leaves `addr_o` unchanged.
- R8: A table write takes effect at the clock edge. A request in the same cycle as a write to its entry sees the old contents, and the next request sees the new contents.
- R9: At most one of `vld_o`, `flt_o` and `pgreq_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Translate request this cycle |
| sel_i | input | 16 | Selector; bits 5:3 index the table in protected mode |
| off_i | input | 32 | Offset (effective address) |
| pe_i | input | 1 | Protection enable; 0 selects real-address mode |
| pg_i | input | 1 | Paging enable |
| wr_en_i | input | 1 | Table write strobe |
| wr_idx_i | input | 3 | Entry to write |
| wr_base_i | input | 32 | Base to write |
| wr_limit_i | input | 20 | Limit to write |
| wr_rights_i | input | 8 | Access-rights byte to write; bit 7 is present |
| addr_o | output | 32 | Physical or linear address |
| vld_o | output | 1 | Address is usable as physical |
| flt_o | output | 1 | Limit or present fault |
| pgreq_o | output | 1 | Linear address needs page translation |

## Verification
A corrupted table entry shows up at the first request that selects it. It appears one clock later as a wrong sum, a spurious fault, or a missing fault at the limit boundary. For this reason the tests place offsets exactly at and one past the limit, and use bases that wrap past 2^32. A wrong index decode shows up as the right sum for the wrong entry, so the tests set the ignored selector bits to non-zero values. Flag priority errors appear in the same cycle as two flags high at once, or as a paging request on a faulting entry.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int ADDR_W  = 32;
  localparam int SEL_W   = 16;
  localparam int LIM_W   = 20;
  localparam int RGT_W   = 8;
  localparam int PRES_B  = 7;
  localparam int RSHIFT  = 4;
  localparam int REAL_W  = SEL_W + RSHIFT;
  localparam int ROFF_W  = 16;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [LIM_W-1:0]  limit;
    logic [RGT_W-1:0]  rights;
  } desc_t;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              vld;
    logic              flt;
    logic              pgreq;
  } xres_t;
endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
  import seg_pkg::*;
#(
  parameter int NENT  = 8,
  parameter int IDX_W = $clog2(NENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  desc_t            wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output desc_t            rd_data_o
);
  desc_t ent_q [NENT];
  desc_t ent_d [NENT];
  logic  load;

  assign load = wr_en_i;

  always_comb begin
    for (int i = 0; i < NENT; i++) begin
      ent_d[i] = ent_q[i];
      if (wr_en_i && (wr_idx_i == IDX_W'(i))) ent_d[i] = wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) ent_q[i] <= '0;
    end else if (load) begin
      for (int i = 0; i < NENT; i++) ent_q[i] <= ent_d[i];
    end
  end

  assign rd_data_o = ent_q[rd_idx_i];
endmodule

// File: rtl/seg_addr_calc.sv
module seg_addr_calc
  import seg_pkg::*;
(
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [ADDR_W-1:0] off_i,
  input  logic              pe_i,
  input  logic              pg_i,
  input  desc_t             desc_i,
  output xres_t             res_o
);
  logic [REAL_W-1:0] real_sum;
  logic [ADDR_W-1:0] lin;
  logic              over_lim;
  logic              absent;
  logic              fault;

  assign real_sum = {sel_i, RSHIFT'(0)} + REAL_W'(off_i[ROFF_W-1:0]);
  assign lin      = desc_i.base + off_i;
  assign over_lim = off_i > ADDR_W'(desc_i.limit);
  assign absent   = !desc_i.rights[PRES_B];
  assign fault    = over_lim || absent;

  always_comb begin
    res_o = '0;
    if (!pe_i) begin
      res_o.addr = ADDR_W'(real_sum);
      res_o.vld  = 1'b1;
    end else if (fault) begin
      res_o.flt  = 1'b1;
    end else if (pg_i) begin
      res_o.addr  = lin;
      res_o.pgreq = 1'b1;
    end else begin
      res_o.addr = lin;
      res_o.vld  = 1'b1;
    end
  end
endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage
  import seg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_i,
  input  xres_t res_i,
  output xres_t res_o
);
  xres_t res_q;
  xres_t res_d;
  logic  upd;

  assign upd = 1'b1;

  always_comb begin
    res_d = res_q;
    if (req_i) begin
      res_d = res_i;
    end else begin
      res_d.vld   = 1'b0;
      res_d.flt   = 1'b0;
      res_d.pgreq = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   res_q <= '0;
    else if (upd) res_q <= res_d;
  end

  assign res_o = res_q;
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_pkg::*;
#(
  parameter int NENT   = 8,
  parameter int IDX_LO = 3,
  localparam int IDX_W = $clog2(NENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [ADDR_W-1:0] off_i,
  input  logic              pe_i,
  input  logic              pg_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_base_i,
  input  logic [LIM_W-1:0]  wr_limit_i,
  input  logic [RGT_W-1:0]  wr_rights_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              vld_o,
  output logic              flt_o,
  output logic              pgreq_o
);
  desc_t wdesc, rdesc;
  xres_t cres, qres;

  assign wdesc.base   = wr_base_i;
  assign wdesc.limit  = wr_limit_i;
  assign wdesc.rights = wr_rights_i;

  seg_desc_table #(.NENT(NENT)) u_tab (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wdesc),
    .rd_idx_i  (sel_i[IDX_LO +: IDX_W]),
    .rd_data_o (rdesc)
  );

  seg_addr_calc u_calc (
    .sel_i  (sel_i),
    .off_i  (off_i),
    .pe_i   (pe_i),
    .pg_i   (pg_i),
    .desc_i (rdesc),
    .res_o  (cres)
  );

  seg_out_stage u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (req_i),
    .res_i (cres),
    .res_o (qres)
  );

  assign addr_o  = qres.addr;
  assign vld_o   = qres.vld;
  assign flt_o   = qres.flt;
  assign pgreq_o = qres.pgreq;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
  import seg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_i,
  input logic              pe_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              vld_o,
  input logic              flt_o,
  input logic              pgreq_o
);
  assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vld_o, flt_o, pgreq_o}));

  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> (!vld_o && !flt_o && !pgreq_o));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> $stable(addr_o));

  assert_real_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !pe_i) |=> (vld_o && addr_o[ADDR_W-1:REAL_W] == '0));

  assert_fltaddr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flt_o |-> (addr_o == '0));
endmodule

bind seg_xlate seg_xlate_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req_i   (req_i),
  .pe_i    (pe_i),
  .addr_o  (addr_o),
  .vld_o   (vld_o),
  .flt_o   (flt_o),
  .pgreq_o (pgreq_o)
);

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i, pe_i, pg_i, wr_en_i;
  logic [15:0] sel_i;
  logic [31:0] off_i, wr_base_i;
  logic [2:0]  wr_idx_i;
  logic [19:0] wr_limit_i;
  logic [7:0]  wr_rights_i;
  logic [31:0] addr_o;
  logic        vld_o, flt_o, pgreq_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlate dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .sel_i(sel_i), .off_i(off_i),
    .pe_i(pe_i), .pg_i(pg_i), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
    .wr_base_i(wr_base_i), .wr_limit_i(wr_limit_i), .wr_rights_i(wr_rights_i),
    .addr_o(addr_o), .vld_o(vld_o), .flt_o(flt_o), .pgreq_o(pgreq_o)
  );

  task automatic expect_out(string tag, logic [31:0] a, logic v, logic f, logic p);
    n_chk++;
    if (addr_o !== a || vld_o !== v || flt_o !== f || pgreq_o !== p) begin
      n_fail++;
      $display("FAIL %s: got addr=%h v=%b f=%b p=%b, expected addr=%h v=%b f=%b p=%b",
               tag, addr_o, vld_o, flt_o, pgreq_o, a, v, f, p);
    end
  endtask

  // Called just after a falling edge; returns just after the next falling edge.
  task automatic issue(logic [15:0] s, logic [31:0] o, logic pe, logic pg);
    sel_i = s; off_i = o; pe_i = pe; pg_i = pg; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic load_desc(logic [2:0] i, logic [31:0] b, logic [19:0] l, logic [7:0] r);
    wr_idx_i = i; wr_base_i = b; wr_limit_i = l; wr_rights_i = r; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req_i = 0; pe_i = 0; pg_i = 0; wr_en_i = 0;
    sel_i = '0; off_i = '0; wr_idx_i = '0; wr_base_i = '0; wr_limit_i = '0; wr_rights_i = '0;
    repeat (3) @(negedge clk);
    expect_out("R1 outputs in reset", 32'h0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1 outputs after reset", 32'h0, 0, 0, 0);
    issue(16'h0010, 32'h0, 1, 0);
    expect_out("R1 entry absent after reset", 32'h0, 0, 1, 0);
  endtask

  task automatic t_real;
    issue(16'h1234, 32'hABCD_5678, 0, 0);
    expect_out("R2 real mode sum", 32'h0001_79B8, 1, 0, 0);
    issue(16'hFFFF, 32'h0000_FFFF, 0, 1);
    expect_out("R2 real mode wrap, paging ignored", 32'h0000_FFEF, 1, 0, 0);
  endtask

  task automatic t_prot;
    load_desc(3'd5, 32'h0010_0000, 20'hFFFFF, 8'h80);
    load_desc(3'd2, 32'hFFFF_F000, 20'hFFFFF, 8'h93);
    issue(16'hFF2B, 32'h0000_1234, 1, 0);
    expect_out("R3 index from bits 5:3", 32'h0010_1234, 1, 0, 0);
    issue(16'h0017, 32'h0000_2000, 1, 0);
    expect_out("R3 base wraps modulo 2^32", 32'h0000_1000, 1, 0, 0);
  endtask

  task automatic t_limit;
    load_desc(3'd3, 32'h0000_4000, 20'h000FF, 8'h80);
    issue(16'h0018, 32'h0000_00FF, 1, 0);
    expect_out("R4 offset equal to limit", 32'h0000_40FF, 1, 0, 0);
    issue(16'h0018, 32'h0000_0100, 1, 0);
    expect_out("R4 offset past limit", 32'h0, 0, 1, 0);
  endtask

  task automatic t_present;
    load_desc(3'd4, 32'h0000_8000, 20'hFFFFF, 8'h7F);
    issue(16'h0020, 32'h0000_0004, 1, 0);
    expect_out("R5 present bit clear", 32'h0, 0, 1, 0);
  endtask

  task automatic t_paging;
    issue(16'h0028, 32'h0000_0040, 1, 1);
    expect_out("R6 paging request", 32'h0010_0040, 0, 0, 1);
    issue(16'h0020, 32'h0000_0004, 1, 1);
    expect_out("R6 fault beats paging", 32'h0, 0, 1, 0);
  endtask

  task automatic t_latency;
    issue(16'h0028, 32'h0000_0777, 1, 0);
    expect_out("R7 result one clock after request", 32'h0010_0777, 1, 0, 0);
    @(negedge clk);
    expect_out("R7 idle clears flags, holds address", 32'h0010_0777, 0, 0, 0);
  endtask

  task automatic t_write_race;
    load_desc(3'd6, 32'h0000_A000, 20'hFFFFF, 8'h80);
    wr_idx_i = 3'd6; wr_base_i = 32'h0000_B000; wr_limit_i = 20'hFFFFF;
    wr_rights_i = 8'h80; wr_en_i = 1'b1;
    issue(16'h0030, 32'h0000_0010, 1, 0);
    wr_en_i = 1'b0;
    expect_out("R8 same-cycle request sees old entry", 32'h0000_A010, 1, 0, 0);
    issue(16'h0030, 32'h0000_0010, 1, 0);
    expect_out("R8 next request sees new entry", 32'h0000_B010, 1, 0, 0);
  endtask

  task automatic t_excl;
    // R9: every expect above checks all three flags; here a mixed burst.
    issue(16'h0000, 32'h0, 0, 1);
    expect_out("R9 real mode single flag", 32'h0, 1, 0, 0);
    issue(16'h0028, 32'h0, 1, 1);
    expect_out("R9 paging single flag", 32'h0010_0000, 0, 0, 1);
  endtask

  initial begin
    t_reset();
    t_real();
    t_prot();
    t_limit();
    t_present();
    t_paging();
    t_latency();
    t_write_race();
    t_excl();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule